// File: doc/BRIEF.md
# Restartable Block Copy Engine

This block copies a run of words from one part of memory to another. A command supplies a 36-bit pointer word and an 18-bit end address. The upper half of the pointer is the source address and the lower half is the destination address. The engine moves words one at a time over a memory port that can refuse any access. The port carries reads, writes, and a write-permission probe that stores nothing.

The pointer register is architectural state and can be read at the ports at all times. For a multi-word run, the engine loads the pointer with the value it will hold at the end of the run before it moves any word. If the run stops early, the engine writes the pointer back with the address pair of the first word it did not transfer. A run stops early when a memory access faults or when the pending-interrupt input is high at a word boundary. Software can then restart the copy from that pointer.

When the end address does not lie above the destination, the engine copies a single word, and a per-command option selects the pointer result. When the destination is the source plus one, the engine reads the source once and replicates that word across the destination block.

Top module: `blt_engine`

## Requirements
- R1: After a synchronous reset, `ptr_o` is zero, `cmd_ready` is 1, and `done_o`, `fault_o`, `intr_o` and `mem_req` are 0.
- R2: A command is accepted when `cmd_valid` and `cmd_ready` are both high. `ptr_o` equals `cmd_ptr` in the cycle after acceptance, and the pointer does not change while the engine is idle with no command offered.
- R3: Let D be `cmd_end` minus the destination, taken as a signed difference. If D > 0, the engine copies D+1 words at ascending addresses. `ptr_o` holds (src+D+1, dst+D+1) from the first memory request onward and keeps that value on success.
- R4: If D > 0 and the destination equals the source plus one (mod 2^18), the source is read exactly once and every destination word receives that value.
- R5: If D <= 0, exactly one word moves from src to dst. When `cmd_rev_full`=1 the resulting pointer is (src+D+1, dst+D+1); when it is 0 the pointer is (src+1, dst+1).
- R6: In the one-word case, the source read and the destination probe both happen before the store. If either faults, nothing is stored, `ptr_o` keeps the accepted value, and `fault_o` is raised.
- R7: If an access faults during a multi-word run, the words before it stay written and the faulting word is not stored. `ptr_o` becomes the address pair of the faulting word and `fault_o` is raised.
- R8: `irq_pend` is sampled once before each word of a multi-word run. If it is high, the run stops before that word's accesses, `ptr_o` becomes that word's address pair, and `intr_o` is raised.
- R9: Each address half advances modulo 2^18 with no carry into the other half, and all pointer results are masked to 18 bits per half.
- R10: Every command ends with one single-cycle `done_o` pulse. `fault_o` and `intr_o` are only high together with `done_o`, never both at once, and `cmd_ready` is low while a memory request is out.
- R11: The memory port operations are `mem_op` 0 = read, 1 = write, 2 = probe write permission without storing. Each request is one cycle of `mem_req`. The engine issues the next request only after `mem_rsp` returns for the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_ptr | input | 36 | Initial pointer: source in [35:18], destination in [17:0] |
| cmd_end | input | 18 | Last destination address |
| cmd_rev_full | input | 1 | Pointer result choice for the one-word case |
| irq_pend | input | 1 | Pending interrupt, checked between words |
| mem_req | output | 1 | One-cycle memory request |
| mem_op | output | 2 | 0 read, 1 write, 2 write probe |
| mem_addr | output | 18 | Memory word address |
| mem_wdata | output | 36 | Write data |
| mem_rsp | input | 1 | Response for the outstanding request |
| mem_rdata | input | 36 | Read data, valid with mem_rsp |
| mem_fault | input | 1 | Access refused, valid with mem_rsp |
| ptr_o | output | 36 | Architectural pointer register |
| done_o | output | 1 | Command finished (pulse) |
| fault_o | output | 1 | Command ended on a memory fault |
| intr_o | output | 1 | Command ended on a pending interrupt |

## Verification
An internal error in the remaining-word counter or the address registers shows in two places. The pointer value reported with the `done_o` pulse is wrong, and destination words outside the intended block are written or left untouched. Both become visible by the end of the command that exposes the error. A wrong mode decision (fill, one-word or normal) shows at once as a changed count of read requests. If the final pointer were written late instead of at the start, the pointer sampled at the first memory request would differ. Aborts are exercised at the first word and in the middle of a run, so that an off-by-one in the restart pointer is visible.

// File: rtl/blt_pkg.sv
package blt_pkg;

  typedef enum logic [1:0] {
    MOP_RD  = 2'd0,
    MOP_WR  = 2'd1,
    MOP_PRB = 2'd2
  } mem_op_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_START,
    S_WORD,
    S_RD,
    S_WR,
    S_SRD,
    S_SPRB,
    S_SWR
  } blt_state_e;

endpackage

// File: rtl/blt_span_calc.sv
module blt_span_calc #(
  parameter int AW = 18
) (
  input  logic [AW-1:0]   src_i,
  input  logic [AW-1:0]   dst_i,
  input  logic [AW-1:0]   end_i,
  input  logic            rev_full_i,
  output logic            single_o,
  output logic            fill_o,
  output logic [AW-1:0]   cnt_o,
  output logic [2*AW-1:0] final_o,
  output logic [2*AW-1:0] single_ptr_o
);

  logic [AW:0]   diff;
  logic [AW-1:0] fin_src, fin_dst, one_src, one_dst;

  // signed span: top bit set means the end lies below the destination
  assign diff     = {1'b0, end_i} - {1'b0, dst_i};
  assign single_o = diff[AW] | (diff == '0);
  assign cnt_o    = diff[AW-1:0];

  // modulo-2^AW arithmetic per half, no carry between halves
  assign fin_src = src_i + cnt_o + AW'(1);
  assign fin_dst = dst_i + cnt_o + AW'(1);
  assign one_src = src_i + AW'(1);
  assign one_dst = dst_i + AW'(1);

  assign final_o      = {fin_src, fin_dst};
  assign single_ptr_o = rev_full_i ? {fin_src, fin_dst} : {one_src, one_dst};
  assign fill_o       = (one_src == dst_i);

endmodule

// File: rtl/blt_ctrl.sv
module blt_ctrl
  import blt_pkg::*;
#(
  parameter int AW = 18,
  parameter int DW = 36
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [2*AW-1:0] cmd_ptr,
  input  logic [AW-1:0]   cmd_end,
  input  logic            cmd_rev_full,
  input  logic            irq_pend,
  input  logic            single_i,
  input  logic            fill_i,
  input  logic [AW-1:0]   cnt_i,
  input  logic [2*AW-1:0] final_i,
  input  logic [2*AW-1:0] single_ptr_i,
  output logic [AW-1:0]   src_o,
  output logic [AW-1:0]   dst_o,
  output logic [AW-1:0]   end_o,
  output logic            rev_o,
  output logic            mem_req,
  output logic [1:0]      mem_op,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic            mem_rsp,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            mem_fault,
  output logic [2*AW-1:0] ptr_o,
  output logic            done_o,
  output logic            fault_o,
  output logic            intr_o
);

  blt_state_e      state_q;
  logic [AW-1:0]   src_q, dst_q, end_q, rem_q;
  logic            rev_q, fill_q;
  logic [DW-1:0]   word_q;
  logic [2*AW-1:0] ptr_q;
  logic            req_q, done_q, fault_q, intr_q;
  mem_op_e         op_q;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   wdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      end_q   <= '0;
      rem_q   <= '0;
      rev_q   <= 1'b0;
      fill_q  <= 1'b0;
      word_q  <= '0;
      ptr_q   <= '0;
      req_q   <= 1'b0;
      op_q    <= MOP_RD;
      addr_q  <= '0;
      wdata_q <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      intr_q  <= 1'b0;
    end else begin
      req_q   <= 1'b0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      intr_q  <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (cmd_valid) begin
            src_q   <= cmd_ptr[2*AW-1:AW];
            dst_q   <= cmd_ptr[AW-1:0];
            end_q   <= cmd_end;
            rev_q   <= cmd_rev_full;
            ptr_q   <= cmd_ptr;
            state_q <= S_START;
          end
        end
        S_START: begin
          if (single_i) begin
            req_q   <= 1'b1;
            op_q    <= MOP_RD;
            addr_q  <= src_q;
            state_q <= S_SRD;
          end else begin
            // final pointer goes in before any word moves
            ptr_q  <= final_i;
            rem_q  <= cnt_i;
            fill_q <= fill_i;
            if (fill_i) begin
              req_q   <= 1'b1;
              op_q    <= MOP_RD;
              addr_q  <= src_q;
              state_q <= S_RD;
            end else begin
              state_q <= S_WORD;
            end
          end
        end
        S_WORD: begin
          if (irq_pend) begin
            ptr_q   <= {src_q, dst_q};
            done_q  <= 1'b1;
            intr_q  <= 1'b1;
            state_q <= S_IDLE;
          end else if (fill_q) begin
            req_q   <= 1'b1;
            op_q    <= MOP_WR;
            addr_q  <= dst_q;
            wdata_q <= word_q;
            state_q <= S_WR;
          end else begin
            req_q   <= 1'b1;
            op_q    <= MOP_RD;
            addr_q  <= src_q;
            state_q <= S_RD;
          end
        end
        S_RD: begin
          if (mem_rsp) begin
            if (mem_fault) begin
              ptr_q   <= {src_q, dst_q};
              done_q  <= 1'b1;
              fault_q <= 1'b1;
              state_q <= S_IDLE;
            end else if (fill_q) begin
              word_q  <= mem_rdata;
              state_q <= S_WORD;
            end else begin
              req_q   <= 1'b1;
              op_q    <= MOP_WR;
              addr_q  <= dst_q;
              wdata_q <= mem_rdata;
              state_q <= S_WR;
            end
          end
        end
        S_WR: begin
          if (mem_rsp) begin
            if (mem_fault) begin
              ptr_q   <= {src_q, dst_q};
              done_q  <= 1'b1;
              fault_q <= 1'b1;
              state_q <= S_IDLE;
            end else begin
              src_q <= src_q + AW'(1);
              dst_q <= dst_q + AW'(1);
              if (rem_q == '0) begin
                done_q  <= 1'b1;
                state_q <= S_IDLE;
              end else begin
                rem_q   <= rem_q - AW'(1);
                state_q <= S_WORD;
              end
            end
          end
        end
        S_SRD: begin
          if (mem_rsp) begin
            if (mem_fault) begin
              done_q  <= 1'b1;
              fault_q <= 1'b1;
              state_q <= S_IDLE;
            end else begin
              word_q  <= mem_rdata;
              req_q   <= 1'b1;
              op_q    <= MOP_PRB;
              addr_q  <= dst_q;
              state_q <= S_SPRB;
            end
          end
        end
        S_SPRB: begin
          if (mem_rsp) begin
            if (mem_fault) begin
              done_q  <= 1'b1;
              fault_q <= 1'b1;
              state_q <= S_IDLE;
            end else begin
              ptr_q   <= single_ptr_i;
              req_q   <= 1'b1;
              op_q    <= MOP_WR;
              addr_q  <= dst_q;
              wdata_q <= word_q;
              state_q <= S_SWR;
            end
          end
        end
        S_SWR: begin
          if (mem_rsp) begin
            done_q  <= 1'b1;
            fault_q <= mem_fault;
            state_q <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign cmd_ready = (state_q == S_IDLE);
  assign src_o     = src_q;
  assign dst_o     = dst_q;
  assign end_o     = end_q;
  assign rev_o     = rev_q;
  assign mem_req   = req_q;
  assign mem_op    = op_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
  assign ptr_o     = ptr_q;
  assign done_o    = done_q;
  assign fault_o   = fault_q;
  assign intr_o    = intr_q;

endmodule

// File: rtl/blt_engine.sv
module blt_engine #(
  parameter int AW = 18,
  parameter int DW = 36
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [2*AW-1:0]    cmd_ptr,
  input  logic [AW-1:0]      cmd_end,
  input  logic               cmd_rev_full,
  input  logic               irq_pend,
  output logic               mem_req,
  output logic [1:0]         mem_op,
  output logic [AW-1:0]      mem_addr,
  output logic [DW-1:0]      mem_wdata,
  input  logic               mem_rsp,
  input  logic [DW-1:0]      mem_rdata,
  input  logic               mem_fault,
  output logic [2*AW-1:0]    ptr_o,
  output logic               done_o,
  output logic               fault_o,
  output logic               intr_o
);

  localparam int PW = 2 * AW;

  logic [AW-1:0] src_w, dst_w, end_w, cnt_w;
  logic          rev_w, single_w, fill_w;
  logic [PW-1:0] final_w, single_ptr_w;

  blt_span_calc #(.AW(AW)) i_calc (
    .src_i        (src_w),
    .dst_i        (dst_w),
    .end_i        (end_w),
    .rev_full_i   (rev_w),
    .single_o     (single_w),
    .fill_o       (fill_w),
    .cnt_o        (cnt_w),
    .final_o      (final_w),
    .single_ptr_o (single_ptr_w)
  );

  blt_ctrl #(.AW(AW), .DW(DW)) i_ctrl (
    .clk          (clk),
    .rst          (rst),
    .cmd_valid    (cmd_valid),
    .cmd_ready    (cmd_ready),
    .cmd_ptr      (cmd_ptr),
    .cmd_end      (cmd_end),
    .cmd_rev_full (cmd_rev_full),
    .irq_pend     (irq_pend),
    .single_i     (single_w),
    .fill_i       (fill_w),
    .cnt_i        (cnt_w),
    .final_i      (final_w),
    .single_ptr_i (single_ptr_w),
    .src_o        (src_w),
    .dst_o        (dst_w),
    .end_o        (end_w),
    .rev_o        (rev_w),
    .mem_req      (mem_req),
    .mem_op       (mem_op),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_rsp      (mem_rsp),
    .mem_rdata    (mem_rdata),
    .mem_fault    (mem_fault),
    .ptr_o        (ptr_o),
    .done_o       (done_o),
    .fault_o      (fault_o),
    .intr_o       (intr_o)
  );

endmodule

// File: rtl/blt_engine_chk.sv
module blt_engine_chk #(
  parameter int AW = 18
) (
  input logic            clk,
  input logic            rst,
  input logic            cmd_valid,
  input logic            cmd_ready,
  input logic            mem_req,
  input logic [2*AW-1:0] ptr_o,
  input logic            done_o,
  input logic            fault_o,
  input logic            intr_o
);

  AST_STATUS_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    (fault_o || intr_o) |-> done_o); // R10

  AST_STATUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(fault_o && intr_o)); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R10

  AST_BUSY_WHILE_REQ: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !cmd_ready); // R10

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req); // R11

  AST_PTR_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (cmd_ready && !cmd_valid) |=> $stable(ptr_o)); // R2

endmodule

bind blt_engine blt_engine_chk #(.AW(AW)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .mem_req   (mem_req),
  .ptr_o     (ptr_o),
  .done_o    (done_o),
  .fault_o   (fault_o),
  .intr_o    (intr_o)
);

// File: tb/test_blt_engine.sv
module test_blt_engine;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [35:0] cmd_ptr = '0;
  logic [17:0] cmd_end = '0;
  logic        cmd_rev_full = 1'b0;
  logic        irq_pend;
  logic        mem_req;
  logic [1:0]  mem_op;
  logic [17:0] mem_addr;
  logic [35:0] mem_wdata;
  logic        mem_rsp = 1'b0;
  logic [35:0] mem_rdata = '0;
  logic        mem_fault = 1'b0;
  logic [35:0] ptr_o;
  logic        done_o, fault_o, intr_o;

  always #5 clk = ~clk;

  blt_engine i_blt_engine (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_ptr(cmd_ptr), .cmd_end(cmd_end), .cmd_rev_full(cmd_rev_full),
    .irq_pend(irq_pend), .mem_req(mem_req), .mem_op(mem_op),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rsp(mem_rsp),
    .mem_rdata(mem_rdata), .mem_fault(mem_fault), .ptr_o(ptr_o),
    .done_o(done_o), .fault_o(fault_o), .intr_o(intr_o)
  );

  // memory model: one-cycle response, 256 words indexed by low address bits
  logic [35:0] mem [0:255];
  int          rd_cnt = 0, wr_cnt = 0, viol = 0;
  logic        pend = 1'b0;
  logic        rd_flt_en = 1'b0, wr_flt_en = 1'b0;
  logic [17:0] rd_flt_addr = '0, wr_flt_addr = '0;
  logic        irq_en = 1'b0;
  int          irq_at = 0, wr_base = 0;
  int          checks = 0, errors = 0;
  logic [35:0] ptr_acc;

  assign irq_pend = irq_en && ((wr_cnt - wr_base) >= irq_at);

  always @(posedge clk) begin
    mem_rsp <= mem_req;
    if (mem_req && pend) viol <= viol + 1;
    if (mem_req) pend <= 1'b1;
    else if (mem_rsp) pend <= 1'b0;
    if (mem_req) begin
      case (mem_op)
        2'd0: begin
          mem_rdata <= mem[mem_addr[7:0]];
          mem_fault <= rd_flt_en && (mem_addr == rd_flt_addr);
          rd_cnt    <= rd_cnt + 1;
        end
        2'd1: begin
          mem_fault <= wr_flt_en && (mem_addr == wr_flt_addr);
          if (!(wr_flt_en && (mem_addr == wr_flt_addr))) begin
            mem[mem_addr[7:0]] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
          end
        end
        default: mem_fault <= wr_flt_en && (mem_addr == wr_flt_addr);
      endcase
    end
  end

  function automatic logic [35:0] pat(input int a);
    return 36'h5A0000000 ^ (36'(a) * 36'd1000003);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic init_mem();
    @(negedge clk);
    for (int i = 0; i < 256; i++) mem[i] = pat(i);
    rd_flt_en = 1'b0;
    wr_flt_en = 1'b0;
    irq_en = 1'b0;
  endtask

  task automatic run_cmd(input logic [17:0] s, input logic [17:0] d, input logic [17:0] e,
                         input logic rev, output logic [35:0] pend_v, output logic f,
                         output logic it, output logic [35:0] pfirst,
                         output int nrd, output int nwr);
    int rd0, wr0, n;
    logic got;
    rd0 = rd_cnt; wr0 = wr_cnt; wr_base = wr_cnt;
    got = 1'b0; pfirst = '0; n = 0;
    cmd_valid = 1'b1; cmd_ptr = {s, d}; cmd_end = e; cmd_rev_full = rev;
    @(negedge clk);
    cmd_valid = 1'b0;
    ptr_acc = ptr_o;
    while (!done_o && n < 5000) begin
      if (mem_req && !got) begin pfirst = ptr_o; got = 1'b1; end
      @(negedge clk);
      n++;
    end
    chk("R10 done pulse seen", 64'(n < 5000), 64'd1);
    pend_v = ptr_o; f = fault_o; it = intr_o;
    nrd = rd_cnt - rd0; nwr = wr_cnt - wr0;
    @(negedge clk);
    chk("R10 done is one cycle", 64'(done_o), 64'd0);
    chk("R10 ready after done", 64'(cmd_ready), 64'd1);
  endtask

  task automatic t_reset();
    chk("R1 ptr reset", 64'(ptr_o), 64'd0);
    chk("R1 ready reset", 64'(cmd_ready), 64'd1);
    chk("R1 status reset", 64'({done_o, fault_o, intr_o, mem_req}), 64'd0);
  endtask

  task automatic t_normal();
    logic [35:0] p, pf; logic f, it; int nr, nw;
    init_mem();
    run_cmd(18'h00010, 18'h00040, 18'h00043, 1'b1, p, f, it, pf, nr, nw);
    chk("R2 ptr after accept", 64'(ptr_acc), 64'({18'h00010, 18'h00040}));
    chk("R3 final ptr early", 64'(pf), 64'({18'h00014, 18'h00044}));
    chk("R3 final ptr", 64'(p), 64'({18'h00014, 18'h00044}));
    chk("R3 no status", 64'({f, it}), 64'd0);
    chk("R3 reads", 64'(nr), 64'd4);
    chk("R3 writes", 64'(nw), 64'd4);
    for (int k = 0; k < 4; k++) chk("R3 data", 64'(mem[8'h40 + k]), 64'(pat(16 + k)));
    chk("R3 beyond end untouched", 64'(mem[8'h44]), 64'(pat(8'h44)));
  endtask

  task automatic t_fill();
    logic [35:0] p, pf; logic f, it; int nr, nw;
    init_mem();
    run_cmd(18'h00020, 18'h00021, 18'h00025, 1'b0, p, f, it, pf, nr, nw);
    chk("R4 single read", 64'(nr), 64'd1);
    chk("R4 writes", 64'(nw), 64'd5);
    for (int k = 1; k <= 5; k++) chk("R4 fill data", 64'(mem[8'h20 + k]), 64'(pat(8'h20)));
    chk("R4 fill ptr", 64'(p), 64'({18'h00025, 18'h00026}));
  endtask

  task automatic t_single();
    logic [35:0] p, pf; logic f, it; int nr, nw;
    init_mem();
    run_cmd(18'h00030, 18'h00050, 18'h00050, 1'b1, p, f, it, pf, nr, nw);
    chk("R5 zero span ptr", 64'(p), 64'({18'h00031, 18'h00051}));
    chk("R5 one word", 64'(mem[8'h50]), 64'(pat(8'h30)));
    chk("R5 next untouched", 64'(mem[8'h51]), 64'(pat(8'h51)));
    chk("R5 one write", 64'(nw), 64'd1);
    init_mem();
    run_cmd(18'h00035, 18'h00060, 18'h0005D, 1'b1, p, f, it, pf, nr, nw);
    chk("R5 reverse full ptr", 64'(p), 64'({18'h00033, 18'h0005E}));
    chk("R5 reverse data", 64'(mem[8'h60]), 64'(pat(8'h35)));
    chk("R5 reverse below untouched", 64'(mem[8'h5F]), 64'(pat(8'h5F)));
    init_mem();
    run_cmd(18'h00035, 18'h00060, 18'h0005D, 1'b0, p, f, it, pf, nr, nw);
    chk("R5 reverse step ptr", 64'(p), 64'({18'h00036, 18'h00061}));
    chk("R5 reverse step write", 64'(nw), 64'd1);
    init_mem();
    run_cmd(18'h00000, 18'h00090, 18'h0008C, 1'b1, p, f, it, pf, nr, nw);
    chk("R9 reverse ptr masked", 64'(p), 64'({18'h3FFFD, 18'h0008D}));
  endtask

  task automatic t_single_fault();
    logic [35:0] p, pf; logic f, it; int nr, nw;
    init_mem();
    wr_flt_en = 1'b1; wr_flt_addr = 18'h00050;
    run_cmd(18'h00010, 18'h00050, 18'h00040, 1'b1, p, f, it, pf, nr, nw);
    chk("R6 probe fault ptr kept", 64'(p), 64'({18'h00010, 18'h00050}));
    chk("R6 probe fault status", 64'({f, it}), 64'b10);
    chk("R6 no store", 64'(mem[8'h50]), 64'(pat(8'h50)));
    chk("R6 read done first", 64'(nr), 64'd1);
    init_mem();
    rd_flt_en = 1'b1; rd_flt_addr = 18'h00010;
    run_cmd(18'h00010, 18'h00050, 18'h00040, 1'b1, p, f, it, pf, nr, nw);
    chk("R6 read fault ptr kept", 64'(p), 64'({18'h00010, 18'h00050}));
    chk("R6 read fault no write", 64'(nw), 64'd0);
  endtask

  task automatic t_run_fault();
    logic [35:0] p, pf; logic f, it; int nr, nw;
    init_mem();
    wr_flt_en = 1'b1; wr_flt_addr = 18'h00082;
    run_cmd(18'h00070, 18'h00080, 18'h00087, 1'b0, p, f, it, pf, nr, nw);
    chk("R7 write fault ptr", 64'(p), 64'({18'h00072, 18'h00082}));
    chk("R7 fault status", 64'({f, it}), 64'b10);
    chk("R7 earlier word kept", 64'(mem[8'h81]), 64'(pat(8'h71)));
    chk("R7 faulting word unstored", 64'(mem[8'h82]), 64'(pat(8'h82)));
    chk("R7 writes", 64'(nw), 64'd2);
    init_mem();
    rd_flt_en = 1'b1; rd_flt_addr = 18'h00090;
    run_cmd(18'h00090, 18'h000B0, 18'h000B3, 1'b0, p, f, it, pf, nr, nw);
    chk("R7 first read fault ptr", 64'(p), 64'({18'h00090, 18'h000B0}));
    chk("R7 first read fault no write", 64'(nw), 64'd0);
  endtask

  task automatic t_irq();
    logic [35:0] p, pf; logic f, it; int nr, nw;
    init_mem();
    irq_en = 1'b1; irq_at = 2;
    run_cmd(18'h000C0, 18'h000D0, 18'h000D5, 1'b0, p, f, it, pf, nr, nw);
    chk("R8 mid irq ptr", 64'(p), 64'({18'h000C2, 18'h000D2}));
    chk("R8 irq status", 64'({f, it}), 64'b01);
    chk("R8 next word untouched", 64'(mem[8'hD2]), 64'(pat(8'hD2)));
    chk("R8 reads stop", 64'(nr), 64'd2);
    init_mem();
    irq_en = 1'b1; irq_at = 0;
    run_cmd(18'h000E0, 18'h000F0, 18'h000F2, 1'b0, p, f, it, pf, nr, nw);
    chk("R8 immediate irq ptr", 64'(p), 64'({18'h000E0, 18'h000F0}));
    chk("R8 immediate no access", 64'(nr + nw), 64'd0);
    init_mem();
    irq_en = 1'b1; irq_at = 3;
    run_cmd(18'h00020, 18'h00021, 18'h00028, 1'b0, p, f, it, pf, nr, nw);
    chk("R8 fill irq ptr", 64'(p), 64'({18'h00023, 18'h00024}));
    chk("R8 fill stopped", 64'(mem[8'h24]), 64'(pat(8'h24)));
    chk("R4 fill before irq", 64'(mem[8'h23]), 64'(pat(8'h20)));
  endtask

  task automatic t_wrap();
    logic [35:0] p, pf; logic f, it; int nr, nw;
    init_mem();
    run_cmd(18'h3FFFE, 18'h001A0, 18'h001A3, 1'b0, p, f, it, pf, nr, nw);
    chk("R9 wrap ptr", 64'(p), 64'({18'h00002, 18'h001A4}));
    chk("R9 wrap data0", 64'(mem[8'hA0]), 64'(pat(8'hFE)));
    chk("R9 wrap data2", 64'(mem[8'hA2]), 64'(pat(8'h00)));
    chk("R9 wrap data3", 64'(mem[8'hA3]), 64'(pat(8'h01)));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_normal();
    t_fill();
    t_single();
    t_single_fault();
    t_run_fault();
    t_irq();
    t_wrap();
    chk("R11 one outstanding request", 64'(viol), 64'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule